// File: doc/BRIEF.md
# Dual-Rate 4:1 Parallel Serializer

This block turns a stream of 4-bit parallel words into a single serial bit stream that runs four times faster than the word rate. Everything runs on one bit-rate clock, which comes in from outside the block. The parallel input clock does not clock any flop in the block. It is sampled as a level on that bit clock, and its transitions decide when a word is captured.

A 2-bit rate mode selects one of two capture styles. In full-rate style only the rising transitions of the parallel clock capture a word. In half-rate style the parallel clock runs at half the frequency and both of its transitions capture a word. The same mode also switches a forwarded serial clock on or off. When that clock is on, its falling edges line up with the instants at which serial data changes.

A diagnostic side output carries either a copy of the serial data or a word-rate clock. A separate enable turns the side output on and off. Because the word rate is fixed by the bit clock, the data path has no back-pressure. A word that is not replaced before the next reload is sent again. A word that is replaced twice between reloads is lost.

Top module: `dual_rate_serializer`

## Requirements
- R1: A 2-bit counter runs on the bit clock, is zero in reset and advances by one on every edge. On every edge where it holds 3 the shift register reloads from the capture register; on all other edges it shifts toward the most significant bit and fills with 0. `sdata_out` is the shift register's bit 3, so each word goes out bit 3 first and bit 0 last. The first reload is on the fourth bit-clock edge after reset is released.
- R2: When `rate_mode[1]` is 1 (full-rate), a word is captured only on a bit-clock edge at which `pclk_in` is 1 and was 0 at the previous edge. A 1-to-0 transition of `pclk_in` leaves the capture register unchanged.
- R3: When `rate_mode[1]` is 0 (half-rate), a word is captured on a bit-clock edge after either a 0-to-1 or a 1-to-0 transition of `pclk_in`.
- R4: The rate modes are encoded as follows: 00 is half-rate with the serial clock on, 01 is half-rate with the serial clock off, 10 is full-rate with the serial clock off, and 11 is full-rate with the serial clock on.
- R5: With the serial clock on, `sclk_out` is the inverted bit clock, so its falling edge coincides with each change of `sdata_out`. With the serial clock off, `sclk_out` is held at 0. The on/off choice takes effect on the next bit-clock edge.
- R6: With `side_pwr` = 1 and `lb_en` = 1, `side_out` equals `sdata_out`. With `side_pwr` = 1 and `lb_en` = 0, `side_out` is the word-rate clock: 1 while the counter holds 2 or 3, and 0 otherwise.
- R7: With `side_pwr` = 0, `side_out` is 0 whatever `lb_en` is.
- R8: While `rst_n` is low, `sdata_out`, `sclk_out` and `side_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pclk_in | input | 1 | Parallel input clock, sampled as a level |
| pdata_in | input | WIDTH | Parallel data word |
| rate_mode | input | 2 | Capture style and serial clock enable (R4) |
| lb_en | input | 1 | Side output source: 1 selects serial data, 0 selects the word clock |
| side_pwr | input | 1 | Side output enable, active high |
| sdata_out | output | 1 | Serial data, bit 3 first |
| sclk_out | output | 1 | Forwarded serial clock, gated |
| side_out | output | 1 | Diagnostic side output |

## Verification
The hardest case to bring about from the ports is a 1-to-0 transition of the parallel clock that wrongly captures a word in full-rate mode. It can only be seen if a different word sits on the data pins at that moment and stays there until the next reload. The stimulus therefore puts the real word on the pins at the rising transition and its bitwise complement one bit clock later, exactly when the falling transition arrives. A capture on the wrong edge would then put the complement on the serial line. In half-rate mode the same complement word arrives with no transition at all, so any capture that is not tied to an edge also shows up in the serial data.

// File: rtl/ser_pkg.sv
package ser_pkg;

  typedef enum logic [1:0] {
    SM_HALF_SCLK   = 2'b00,
    SM_HALF_NOSCLK = 2'b01,
    SM_FULL_NOSCLK = 2'b10,
    SM_FULL_SCLK   = 2'b11
  } ser_mode_e;

  function automatic logic mode_is_half(input ser_mode_e m);
    return (m == SM_HALF_SCLK) || (m == SM_HALF_NOSCLK);
  endfunction

  function automatic logic mode_sclk_on(input ser_mode_e m);
    return (m == SM_HALF_SCLK) || (m == SM_FULL_SCLK);
  endfunction

endpackage

// File: rtl/ser_capture.sv
module ser_capture #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pclk_in,
  input  logic             half_rate,
  input  logic [WIDTH-1:0] pdata_in,
  output logic [WIDTH-1:0] hold_o
);

  logic             pclk_q;
  logic             pclk_rise;
  logic             pclk_fall;
  logic             take;
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pclk_q <= 1'b0;
    else        pclk_q <= pclk_in;
  end

  assign pclk_rise = pclk_in & ~pclk_q;
  assign pclk_fall = ~pclk_in & pclk_q;
  assign take      = pclk_rise | (half_rate & pclk_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (take) hold_q <= pdata_in;
  end

  assign hold_o = hold_q;

  // R2
  full_fall_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_rate && !pclk_in && pclk_q) |=> $stable(hold_q));

  // R3
  half_fall_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_rate && !pclk_in && pclk_q) |=> (hold_q == $past(pdata_in)));

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] word_i,
  output logic             sdata_o,
  output logic             wclk_o
);

  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] sh_q;
  logic             reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign reload = (cnt_q == LAST);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic nxt;
    if (i == 0) begin : g_lsb
      assign nxt = 1'b0;
    end else begin : g_up
      assign nxt = sh_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh_q[i] <= 1'b0;
      else if (reload) sh_q[i] <= word_i[i];
      else             sh_q[i] <= nxt;
    end
  end

  assign sdata_o = sh_q[WIDTH-1];
  assign wclk_o  = cnt_q[CNT_W-1];

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R1
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (sh_q == $past(word_i)));

  // R1
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> (sh_q == {$past(sh_q[WIDTH-2:0]), 1'b0}));

endmodule

// File: rtl/ser_outsel.sv
module ser_outsel (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_on,
  input  logic sdata_i,
  input  logic wclk_i,
  input  logic lb_en,
  input  logic side_pwr,
  output logic sclk_out,
  output logic side_out
);

  logic sclk_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_en_q <= 1'b0;
    else        sclk_en_q <= sclk_on;
  end

  assign sclk_out = sclk_en_q & ~clk;
  assign side_out = side_pwr & (lb_en ? sdata_i : wclk_i);

  // R6
  side_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (side_pwr && lb_en) |-> (side_out == sdata_i));

  // R7
  side_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !side_pwr |-> !side_out);

endmodule

// File: rtl/dual_rate_serializer.sv
module dual_rate_serializer #(
  parameter int WIDTH = 4
) (
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic             pclk_in,
  input  logic [WIDTH-1:0] pdata_in,
  input  logic [1:0]       rate_mode,
  input  logic             lb_en,
  input  logic             side_pwr,
  output logic             sdata_out,
  output logic             sclk_out,
  output logic             side_out
);

  import ser_pkg::*;

  ser_mode_e        mode;
  logic [WIDTH-1:0] hold;
  logic             sdata;
  logic             wclk;

  assign mode = ser_mode_e'(rate_mode);

  ser_capture #(.WIDTH(WIDTH)) u_cap (
    .clk       (clk_bit),
    .rst_n     (rst_n),
    .pclk_in   (pclk_in),
    .half_rate (mode_is_half(mode)),
    .pdata_in  (pdata_in),
    .hold_o    (hold)
  );

  ser_shifter #(.WIDTH(WIDTH)) u_shf (
    .clk     (clk_bit),
    .rst_n   (rst_n),
    .word_i  (hold),
    .sdata_o (sdata),
    .wclk_o  (wclk)
  );

  ser_outsel u_out (
    .clk      (clk_bit),
    .rst_n    (rst_n),
    .sclk_on  (mode_sclk_on(mode)),
    .sdata_i  (sdata),
    .wclk_i   (wclk),
    .lb_en    (lb_en),
    .side_pwr (side_pwr),
    .sclk_out (sclk_out),
    .side_out (side_out)
  );

  assign sdata_out = sdata;

endmodule

// File: tb/test_dual_rate_serializer.sv
module test_dual_rate_serializer;

  localparam int NW = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pclk_in = 1'b0;
  logic [3:0] pdata_in = '0;
  logic [1:0] rate_mode = '0;
  logic       lb_en = 1'b0;
  logic       side_pwr = 1'b0;
  logic       sdata_out, sclk_out, side_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_rate_serializer #(.WIDTH(4)) i_dual_rate_serializer (
    .clk_bit(clk), .rst_n(rst_n), .pclk_in(pclk_in), .pdata_in(pdata_in),
    .rate_mode(rate_mode), .lb_en(lb_en), .side_pwr(side_pwr),
    .sdata_out(sdata_out), .sclk_out(sclk_out), .side_out(side_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] word_of(input int n, input int cfg);
    return 4'((n * 7 + cfg * 3) & 15);
  endfunction

  task automatic run_cfg(input int cfg);
    logic [1:0] m;
    bit full, sclk_on, lb, pwr;
    m = 2'(cfg & 3);
    lb = cfg[2];
    pwr = cfg[3];
    full = m[1];
    sclk_on = (m == 2'b00) || (m == 2'b11);
    @(negedge clk);
    rst_n = 1'b0;
    pclk_in = 1'b0;
    pdata_in = 4'hF;
    rate_mode = m;
    lb_en = lb;
    side_pwr = pwr;
    @(negedge clk);
    @(negedge clk);
    // R8 reset state
    check(sdata_out == 1'b0, "R8 sdata", int'(sdata_out), 0);
    check(sclk_out == 1'b0, "R8 sclk", int'(sclk_out), 0);
    check(side_out == 1'b0, "R8 side", int'(side_out), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4 * NW; k++) begin
      logic exp_sd, exp_wc, exp_side;
      int p, n;
      @(negedge clk);
      if (k < 3) exp_sd = 1'b0;
      else begin
        int mm, wn, j;
        logic [3:0] w;
        mm = k - 3;
        wn = mm / 4;
        j = mm % 4;
        w = word_of(wn, cfg);
        exp_sd = w[3 - j];
      end
      exp_wc = (((k + 1) % 4) >= 2);
      exp_side = pwr ? (lb ? exp_sd : exp_wc) : 1'b0;
      // R1 serial order; R2 / R3 capture edges for the mode in use (R4)
      check(sdata_out == exp_sd, full ? "R1 R2 R4 sdata" : "R1 R3 R4 sdata",
            int'(sdata_out), int'(exp_sd));
      // R5 low phase of bit clock: serial clock shows enable
      check(sclk_out == sclk_on, "R5 R4 sclk low phase", int'(sclk_out), int'(sclk_on));
      // R6 / R7 side output
      check(side_out == exp_side, pwr ? "R6 side" : "R7 side", int'(side_out), int'(exp_side));
      p = k % 4;
      n = k / 4;
      if (p == 0) begin
        pclk_in = full ? 1'b1 : ~pclk_in;
        pdata_in = word_of(n, cfg);
      end else if (p == 1) begin
        if (full) pclk_in = 1'b0;
        pdata_in = ~word_of(n, cfg);
      end
      @(posedge clk);
      #1;
      // R5 high phase of bit clock: serial clock is low
      check(sclk_out == 1'b0, "R5 sclk high phase", int'(sclk_out), 0);
    end
  endtask

  initial begin
    for (int cfg = 0; cfg < 16; cfg++) run_cfg(cfg);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(10 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule